// File: doc/BRIEF.md
# Scaled-Index Address Adder

This combinational execution unit serves a 64-bit integer pipeline. It computes the results of the address-generation group of bit-manipulation operations. Each operation shifts the first register operand left by a small fixed amount and adds the second operand, which is how an array index becomes a byte address. Variants of these operations first reduce the first operand to its unsigned low 32-bit word. A final variant places that word at an immediate bit position. The execute stage presents a function code, two operands, an immediate shift amount, the current register-width mode and an extension-enable bit. It takes the result or the illegal-operation flag in the same cycle.

Word-form operations only make sense when registers are 64 bits wide. In 32-bit mode the unit rejects them. When the extension is disabled it rejects every function. A rejected operation always returns a zero result, so a downstream stage never forwards a stale or partial value.

Top module: `shadd_unit`

## Requirements
- R1: Function codes 3'b000, 3'b001 and 3'b010 return (A << N) + B, where N is the code plus one (1, 2 or 3). The sum wraps modulo 2^64 and there is no carry output.
- R2: Function codes 3'b100, 3'b101 and 3'b110 return (zero-extended A[31:0] << N) + B, where N is the low two code bits plus one. B is added at its full 64-bit width.
- R3: Function code 3'b011 returns zero-extended A[31:0] + B with no shift, wrapping modulo 2^64.
- R4: Function code 3'b111 returns zero-extended A[31:0] shifted left by the 6-bit immediate (0..63), truncated to 64 bits. Every bit below the immediate position is zero, and B has no effect on the result.
- R5: When the width mode input is low (32-bit), codes 3'b011 through 3'b111 raise the illegal flag and return zero. Codes 3'b000 to 3'b010 stay legal in that mode.
- R6: When the extension-enable input is low, every function code raises the illegal flag and the result is zero.
- R7: The immediate shift amount has no effect on any function code other than 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| func_i | input | 3 | Function code, encoding given in R1 to R4 |
| mode64_i | input | 1 | 1 = 64-bit register mode, 0 = 32-bit mode |
| ext_en_i | input | 1 | Extension enable; 0 rejects every function |
| src_a_i | input | 64 | First operand (index or word to place) |
| src_b_i | input | 64 | Second operand (base) |
| shamt_i | input | 6 | Immediate shift amount for code 3'b111 |
| result_o | output | 64 | Result, zero when illegal |
| illegal_o | output | 1 | Operation rejected |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath, a 32-bit word and a largest scale of three. With these values the 6-bit immediate spans every position from 0 to 63. So the bench reaches the placements above bit 32, where the upper part of the word falls off the top, as well as shifts of zero and 63. A 64-bit datapath also makes the carry out of bit 63 in the scaled sums reachable. The bench drives all-ones operands at every scale, together with dirty upper halves on A for the word forms, so that wrap-around and discarding A's upper half are both exercised.

// File: rtl/shadd_pkg.sv
// Shared types of the scaled-index address adder.
// Assumes: function codes are fixed by the execute-stage encoding.
package shadd_pkg;

    localparam int FN_W = 3;

    typedef enum logic [FN_W-1:0] {
        FN_SCL1_ADD   = 3'b000,
        FN_SCL2_ADD   = 3'b001,
        FN_SCL3_ADD   = 3'b010,
        FN_WORD_ADD   = 3'b011,
        FN_SCL1_WADD  = 3'b100,
        FN_SCL2_WADD  = 3'b101,
        FN_SCL3_WADD  = 3'b110,
        FN_WORD_PLACE = 3'b111
    } shadd_fn_e;

endpackage

// File: rtl/shadd_decode.sv
// Function decoder: turns the function code, width mode and enable
// into datapath controls and the illegal flag.
// Assumes: all eight codes are defined; only legality depends on mode.
module shadd_decode
    import shadd_pkg::*;
#(
    parameter int MAX_SCALE = 3,
    localparam int SCALE_W  = $clog2(MAX_SCALE + 1)
) (
    input  logic [FN_W-1:0]    func_i,
    input  logic               mode64_i,
    input  logic               ext_en_i,
    output logic [SCALE_W-1:0] scale_o,
    output logic               word_zext_o,
    output logic               place_o,
    output logic               illegal_o
);

    shadd_fn_e fn;
    logic      word_form;

    // Classify the function code into scale, word form and placement.
    always_comb begin
        fn          = shadd_fn_e'(func_i);
        scale_o     = '0;
        word_zext_o = 1'b0;
        place_o     = 1'b0;
        word_form   = 1'b0;
        case (fn)
            FN_SCL1_ADD:   scale_o = SCALE_W'(1);
            FN_SCL2_ADD:   scale_o = SCALE_W'(2);
            FN_SCL3_ADD:   scale_o = SCALE_W'(3);
            FN_WORD_ADD: begin
                word_form   = 1'b1;
                word_zext_o = 1'b1;
            end
            FN_SCL1_WADD: begin
                word_form   = 1'b1;
                word_zext_o = 1'b1;
                scale_o     = SCALE_W'(1);
            end
            FN_SCL2_WADD: begin
                word_form   = 1'b1;
                word_zext_o = 1'b1;
                scale_o     = SCALE_W'(2);
            end
            FN_SCL3_WADD: begin
                word_form   = 1'b1;
                word_zext_o = 1'b1;
                scale_o     = SCALE_W'(3);
            end
            FN_WORD_PLACE: begin
                word_form   = 1'b1;
                place_o     = 1'b1;
            end
            default: ;
        endcase
    end

    // Reject everything when disabled, and word forms in 32-bit mode.
    always_comb begin
        illegal_o = !ext_en_i || (word_form && !mode64_i);
    end

endmodule

// File: rtl/shadd_prescale.sv
// Operand pre-scaler: optionally narrows the first operand to its
// zero-extended low word, then shifts it left by 0..MAX_SCALE.
// Assumes: scale never exceeds MAX_SCALE.
module shadd_prescale #(
    parameter int XLEN      = 64,
    parameter int WORD_W    = 32,
    parameter int MAX_SCALE = 3,
    localparam int SCALE_W  = $clog2(MAX_SCALE + 1)
) (
    input  logic [XLEN-1:0]    src_i,
    input  logic               word_zext_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [XLEN-1:0]    scaled_o
);

    logic [XLEN-1:0] narrowed;
    logic [XLEN-1:0] cand [MAX_SCALE+1];

    // Select the full operand or its zero-extended low word.
    always_comb begin
        narrowed = word_zext_i ? {{(XLEN-WORD_W){1'b0}}, src_i[WORD_W-1:0]} : src_i;
    end

    // One fixed-shift candidate per legal scale.
    for (genvar s = 0; s <= MAX_SCALE; s++) begin : g_cand
        assign cand[s] = narrowed << s;
    end

    // Pick the candidate for the requested scale.
    always_comb begin
        scaled_o = cand[0];
        for (int s = 1; s <= MAX_SCALE; s++) begin
            if (int'(scale_i) == s) scaled_o = cand[s];
        end
    end

    // Guard: shifted-in positions are clear, and word forms leave no high bits.
    always_comb begin
        if (!$isunknown({scaled_o, scale_i, word_zext_i})) begin
            a_r1_low_clear: assert ((scaled_o & ((XLEN'(1) << scale_i) - XLEN'(1))) == '0)
                else $error("pre-scaler left bits below the scale position");
            if (word_zext_i) begin
                a_r2_high_clear: assert ((scaled_o >> (WORD_W + int'(scale_i))) == '0)
                    else $error("word form kept upper operand bits");
            end
        end
    end

endmodule

// File: rtl/shadd_place.sv
// Word placer: puts the zero-extended low word of the operand at an
// immediate bit position; bits pushed past the top are dropped.
// Assumes: shamt covers 0..XLEN-1.
module shadd_place #(
    parameter int XLEN     = 64,
    parameter int WORD_W   = 32,
    localparam int SHAMT_W = $clog2(XLEN)
) (
    input  logic [XLEN-1:0]    src_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    output logic [XLEN-1:0]    placed_o
);

    logic [XLEN-1:0] word_ext;

    // Zero-extend the low word and shift it into place.
    always_comb begin
        word_ext = {{(XLEN-WORD_W){1'b0}}, src_i[WORD_W-1:0]};
        placed_o = word_ext << shamt_i;
    end

    // Guard: nothing below the placement position, and the field reads back.
    always_comb begin
        if (!$isunknown({placed_o, shamt_i, src_i})) begin
            a_r4_below_clear: assert ((placed_o & ((XLEN'(1) << shamt_i) - XLEN'(1))) == '0)
                else $error("placement left bits below shamt");
            a_r4_field_back: assert (((placed_o >> shamt_i) & {{(XLEN-WORD_W){1'b0}}, {WORD_W{1'b1}}})
                                     == (src_i[WORD_W-1:0] & ({WORD_W{1'b1}} >> ((int'(shamt_i) > XLEN-WORD_W) ?
                                         (int'(shamt_i) - (XLEN-WORD_W)) : 0))))
                else $error("placed field does not match source word");
        end
    end

endmodule

// File: rtl/shadd_unit.sv
// Scaled-index address adder, top level. Pure combinational: decode,
// pre-scale, one shared adder, word placer, and a zeroing output mux.
// Assumes: the caller samples result and illegal flag in the same cycle.
module shadd_unit
    import shadd_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int WORD_W    = 32,
    parameter int MAX_SCALE = 3,
    localparam int SHAMT_W  = $clog2(XLEN),
    localparam int SCALE_W  = $clog2(MAX_SCALE + 1)
) (
    input  logic [FN_W-1:0]    func_i,
    input  logic               mode64_i,
    input  logic               ext_en_i,
    input  logic [XLEN-1:0]    src_a_i,
    input  logic [XLEN-1:0]    src_b_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    output logic [XLEN-1:0]    result_o,
    output logic               illegal_o
);

    logic [SCALE_W-1:0] scale;
    logic               word_zext;
    logic               place;
    logic               illegal;
    logic [XLEN-1:0]    scaled;
    logic [XLEN-1:0]    placed;
    logic [XLEN-1:0]    sum;

    shadd_decode #(.MAX_SCALE(MAX_SCALE)) i_decode (
        .func_i      (func_i),
        .mode64_i    (mode64_i),
        .ext_en_i    (ext_en_i),
        .scale_o     (scale),
        .word_zext_o (word_zext),
        .place_o     (place),
        .illegal_o   (illegal)
    );

    shadd_prescale #(.XLEN(XLEN), .WORD_W(WORD_W), .MAX_SCALE(MAX_SCALE)) i_prescale (
        .src_i       (src_a_i),
        .word_zext_i (word_zext),
        .scale_i     (scale),
        .scaled_o    (scaled)
    );

    shadd_place #(.XLEN(XLEN), .WORD_W(WORD_W)) i_place (
        .src_i    (src_a_i),
        .shamt_i  (shamt_i),
        .placed_o (placed)
    );

    // Shared modulo-2^XLEN adder for every add-type function.
    always_comb begin
        sum = scaled + src_b_i;
    end

    // Pick the functional result; a rejected operation returns zero.
    always_comb begin
        illegal_o = illegal;
        if (illegal)    result_o = '0;
        else if (place) result_o = placed;
        else            result_o = sum;
    end

    // Guard: disable and 32-bit-mode rules seen at the ports.
    always_comb begin
        if (!$isunknown({ext_en_i, mode64_i, func_i, result_o, illegal_o})) begin
            if (!ext_en_i) begin
                a_r6_disabled_zero: assert (illegal_o && result_o == '0)
                    else $error("disabled unit produced a result");
            end
            if (!mode64_i && func_i >= FN_W'(FN_WORD_ADD)) begin
                a_r5_word_rejected: assert (illegal_o && result_o == '0)
                    else $error("word form accepted in 32-bit mode");
            end
        end
    end

endmodule

// File: tb/test_shadd_unit.sv
module test_shadd_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  func;
    logic        mode64;
    logic        ext_en;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic [5:0]  shamt;
    logic [63:0] result;
    logic        illegal;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    shadd_unit i_shadd_unit (
        .func_i    (func),
        .mode64_i  (mode64),
        .ext_en_i  (ext_en),
        .src_a_i   (src_a),
        .src_b_i   (src_b),
        .shamt_i   (shamt),
        .result_o  (result),
        .illegal_o (illegal)
    );

    // Behavioural reference written from the requirements.
    function automatic void model(input int fn, input bit m64, input bit en,
                                  input logic [63:0] a, input logic [63:0] b,
                                  input int sh, output logic [63:0] r, output bit ill);
        longint unsigned ua, ub, w;
        ua = a; ub = b; w = ua & 64'hFFFF_FFFF;
        ill = !en || (!m64 && fn >= 3);
        if (ill) r = 0;
        else if (fn <= 2) r = (ua << (fn + 1)) + ub;
        else if (fn == 3) r = w + ub;
        else if (fn <= 6) r = (w << (fn - 3)) + ub;
        else r = w << sh;
    endfunction

    function automatic string tag_of(input int fn, input bit m64, input bit en);
        if (!en) return "R6";
        if (!m64 && fn >= 3) return "R5";
        if (fn <= 2) return "R1";
        if (fn == 3) return "R3";
        if (fn <= 6) return "R2";
        return "R4";
    endfunction

    task automatic apply(input int fn, input bit m64, input bit en,
                         input logic [63:0] a, input logic [63:0] b, input int sh);
        @(posedge clk);
        func = 3'(fn); mode64 = m64; ext_en = en; src_a = a; src_b = b; shamt = 6'(sh);
    endtask

    task automatic check(input string tag);
        logic [63:0] er;
        bit          ei;
        @(negedge clk);
        model(int'(func), mode64, ext_en, src_a, src_b, int'(shamt), er, ei);
        n_tests++;
        if (result !== er || illegal !== ei) begin
            n_fail++;
            $display("FAIL %s: fn=%0d m64=%0b en=%0b got res=%h ill=%0b exp res=%h ill=%0b",
                     tag, func, mode64, ext_en, result, illegal, er, ei);
        end
    endtask

    task automatic run(input int fn, input bit m64, input bit en,
                       input logic [63:0] a, input logic [63:0] b, input int sh, input string tag);
        apply(fn, m64, en, a, b, sh);
        check(tag);
    endtask

    initial begin
        func = 3'd0; mode64 = 1'b0; ext_en = 1'b0;
        src_a = '0; src_b = '0; shamt = '0;
        repeat (3) @(posedge clk);
        // reset state: disabled, all inputs zero
        @(negedge clk);
        n_tests++;
        if (result !== 64'd0 || illegal !== 1'b1) begin
            n_fail++;
            $display("FAIL R6 reset: got res=%h ill=%0b exp res=0 ill=1", result, illegal);
        end
        rst_n = 1'b1;

        // R1 wrap at each scale with all-ones operands
        for (int fn = 0; fn <= 2; fn++)
            run(fn, 1'b1, 1'b1, '1, '1, 0, "R1");
        run(0, 1'b0, 1'b1, 64'h8000_0000_0000_0001, 64'd5, 0, "R1");
        // R2 and R3 with dirty upper half of A
        for (int fn = 3; fn <= 6; fn++)
            run(fn, 1'b1, 1'b1, 64'hDEAD_BEEF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0001, 0,
                fn == 3 ? "R3" : "R2");
        // R4 boundary placements, B must not matter
        for (int sh = 0; sh < 64; sh++)
            run(7, 1'b1, 1'b1, 64'hFFFF_0000_8765_4321, '1, sh, "R4");
        run(7, 1'b1, 1'b1, 64'h1234_5678_8765_4321, 64'd0, 40, "R4");
        // R5 every code in 32-bit mode
        for (int fn = 0; fn < 8; fn++)
            run(fn, 1'b0, 1'b1, 64'h0000_0000_0000_1000, 64'd7, 3, "R5");
        // R6 every code disabled in both modes
        for (int fn = 0; fn < 8; fn++) begin
            run(fn, 1'b1, 1'b0, '1, '1, 9, "R6");
            run(fn, 1'b0, 1'b0, '1, '1, 9, "R6");
        end
        // R7 immediate ignored off the placement code
        for (int fn = 0; fn < 7; fn++) begin
            run(fn, 1'b1, 1'b1, 64'h0123_4567_89AB_CDEF, 64'h1111, 0, "R7");
            run(fn, 1'b1, 1'b1, 64'h0123_4567_89AB_CDEF, 64'h1111, 63, "R7");
        end
        // random sweep compared every clock
        for (int i = 0; i < 3000; i++) begin
            int fn;
            bit m, e;
            fn = int'($urandom_range(0, 7));
            m  = ($urandom_range(0, 3) != 0);
            e  = ($urandom_range(0, 7) != 0);
            run(fn, m, e, {$urandom, $urandom}, {$urandom, $urandom},
                int'($urandom_range(0, 63)), tag_of(fn, m, e));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule